// File: doc/BRIEF.md
# Byte-Stream Register Access Packet Engine

This block sits behind a byte-wide serial link and carries out register accesses for a host. The host sends a fixed 16-byte request. It holds a sync byte, a command byte and up to seven address/data byte pairs. The engine waits for the sync value, checks that the command asks for exactly one direction, and performs the access. The target is either its own byte-addressed configuration bank or one of three outside devices that share a request/acknowledge register port. It then streams back a 16-byte answer. The answer repeats the request, and on a read the returned values replace the data bytes.

The configuration bank holds several writable control words, a read-only version word and two live 64-bit timestamps supplied from outside. The host reaches every multi-byte field one byte per access, least significant byte at the lowest address. Only a bank read may walk more than one pair. Every other access acts on the first pair alone.

Top module: `regpkt_engine`

## Requirements
- R1: A request is 16 bytes taken on `rx_valid && rx_ready`. Byte 0 must be 0x4E and byte 1 is the command byte, whose fields are: bit 7 read, bit 6 write, bits 5:4 target (0 bank, 1 device A, 2 trim device, 3 device B), bit 3 ignored, bits 2:0 pair count. Bytes 2 to 15 are pairs, address at the even offset and data at the odd offset. Each accepted request produces a 16-byte answer sent in order 0 to 15 on `tx_valid && tx_ready`. Answer byte 0 is 0x4E and answer byte 1 equals the request's command byte.
- R2: While waiting for a request, any byte other than 0x4E is consumed and discarded. The next 0x4E starts a new request.
- R3: A request whose command byte has both or neither of bits 7 and 6 set is abandoned at that byte, and no answer is sent. The engine returns to waiting for 0x4E.
- R4: A bank write stores the data byte of pair 0 at the address of pair 0 when that address is writable (0 to 11 and 34 to 47). The stored byte appears on `cfg_image` at bits [8*addr+7 : 8*addr] and is returned by later reads. Multi-byte fields are little-endian.
- R5: A bank read reads pairs 0 to count-1 in order, with a count of 0 acting as 1. The value read for pair i is placed at answer byte 3+2*i.
- R6: Bank bytes 12 to 15 return the `VERSION` parameter, least significant byte at 12. Writes to them leave `cfg_image` unchanged.
- R7: Bank addresses 32, 33 and 48 to 255 read as 0x00, and writes to them leave `cfg_image` unchanged.
- R8: Bank bytes 16 to 23 return `ts_rx` and bytes 24 to 31 return `ts_tx`, least significant byte first.
- R9: A request to target 1, 2 or 3 makes exactly one transfer on the device port, whatever the count. The transfer carries `ext_sel` = target, `ext_addr` = byte 2, `ext_wr` = the write bit and `ext_wdata` = byte 3. On a read, `ext_rdata` captured at the acknowledge is returned in answer byte 3.
- R10: `ext_req` stays high, with address, data, select and direction stable, until `ext_ack` is seen.
- R11: `rx_ready` is low from the cycle after the last request byte until the last answer byte is taken. While `tx_ready` is low, `tx_valid` and `tx_data` hold.
- R12: After reset `rx_ready` is 1, `tx_valid` is 0, `ext_req` is 0 and `cfg_image` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Request byte present |
| rx_data | input | 8 | Request byte |
| rx_ready | output | 1 | Engine accepts a request byte |
| tx_valid | output | 1 | Answer byte present |
| tx_data | output | 8 | Answer byte |
| tx_ready | input | 1 | Downstream takes the answer byte |
| ext_req | output | 1 | Device port transfer request |
| ext_sel | output | 2 | Target code of the transfer (1, 2 or 3) |
| ext_wr | output | 1 | Transfer is a write |
| ext_addr | output | 8 | Device register address |
| ext_wdata | output | 8 | Device write data |
| ext_rdata | input | 8 | Device read data, valid with ext_ack |
| ext_ack | input | 1 | Device completes the transfer |
| ts_rx | input | 64 | Live receive timestamp |
| ts_tx | input | 64 | Live transmit timestamp |
| cfg_image | output | 8*BANK_BYTES | Writable bank bytes, zero at other addresses |

## Verification
Two functions can fall in the same cycle: draining an answer to the link and taking the next request from it. The bench provokes this by driving the next request with `rx_valid` held high while the previous answer is still being drained under random `tx_ready` stalls. Every cycle it checks that `tx_valid` and `rx_ready` are never both high. It then requires the second request to be answered with its own correct read data, which shows that no byte was taken early or lost.

// File: rtl/regpkt_pkg.sv
package regpkt_pkg;
   localparam int unsigned PKT_BYTES = 16;
   localparam logic [7:0]  PKT_MAGIC = 8'h4E;
   localparam int unsigned MAP_BYTES = 48;
   localparam int unsigned VER_BASE  = 12;
   localparam int unsigned TSRX_BASE = 16;
   localparam int unsigned TSTX_BASE = 24;
   localparam int unsigned TRIM_BASE = 34;
   localparam int unsigned TS_BYTES  = 8;

   localparam logic [1:0] TGT_BANK = 2'b00;

   typedef enum logic [2:0] {
      CS_RECV,
      CS_DECODE,
      CS_BANK,
      CS_EXT,
      CS_SEND
   } core_state_t;

   // Byte addresses held in bank storage and open to writes.
   function automatic logic byte_writable(int unsigned a);
      return (a < VER_BASE) || (a >= TRIM_BASE && a < MAP_BYTES);
   endfunction
endpackage

// File: rtl/regpkt_rx.sv
module regpkt_rx
   import regpkt_pkg::*;
#(
   parameter int unsigned NBYTES = PKT_BYTES,
   parameter logic [7:0]  MAGIC  = PKT_MAGIC
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [7:0]          in_data,
   input  logic                hold,
   output logic                in_ready,
   output logic                frame_done,
   output logic [NBYTES*8-1:0] frame
);
   localparam int unsigned IW = $clog2(NBYTES);

   if (NBYTES < 4) begin : g_bad_len
      $error("regpkt_rx: NBYTES must be at least 4");
   end

   logic [IW-1:0] idx_q;
   logic [7:0]    buf_q [NBYTES];
   logic          take;
   logic          dir_ok;

   assign in_ready = !hold && !frame_done;
   assign take     = in_valid && in_ready;
   assign dir_ok   = in_data[7] ^ in_data[6];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q      <= '0;
         frame_done <= 1'b0;
      end else begin
         frame_done <= 1'b0;
         if (take) begin
            if (idx_q == '0) begin
               if (in_data == MAGIC) idx_q <= IW'(1);
            end else if (idx_q == IW'(1)) begin
               idx_q <= dir_ok ? IW'(2) : '0;
            end else if (idx_q == IW'(NBYTES - 1)) begin
               idx_q      <= '0;
               frame_done <= 1'b1;
            end else begin
               idx_q <= idx_q + IW'(1);
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (take) buf_q[idx_q] <= in_data;
   end

   for (genvar k = 0; k < NBYTES; k++) begin : g_flat
      assign frame[k*8 +: 8] = buf_q[k];
   end

   // R2
   frame_magic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (buf_q[0] == MAGIC));

   // R3
   frame_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (buf_q[1][7] != buf_q[1][6]));
endmodule

// File: rtl/regpkt_ext.sv
module regpkt_ext (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       start_wr,
   input  logic [1:0] start_sel,
   input  logic [7:0] start_addr,
   input  logic [7:0] start_wdata,
   input  logic       ext_ack,
   input  logic [7:0] ext_rdata,
   output logic       ext_req,
   output logic [1:0] ext_sel,
   output logic       ext_wr,
   output logic [7:0] ext_addr,
   output logic [7:0] ext_wdata,
   output logic       done,
   output logic [7:0] rdata
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ext_req   <= 1'b0;
         ext_sel   <= '0;
         ext_wr    <= 1'b0;
         ext_addr  <= '0;
         ext_wdata <= '0;
         done      <= 1'b0;
         rdata     <= '0;
      end else begin
         done <= 1'b0;
         if (!ext_req && start) begin
            ext_req   <= 1'b1;
            ext_sel   <= start_sel;
            ext_wr    <= start_wr;
            ext_addr  <= start_addr;
            ext_wdata <= start_wdata;
         end else if (ext_req && ext_ack) begin
            ext_req <= 1'b0;
            done    <= 1'b1;
            rdata   <= ext_rdata;
         end
      end
   end

   // R10
   ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_req && !ext_ack |=> ext_req && $stable(ext_addr) && $stable(ext_wdata)
                              && $stable(ext_sel) && $stable(ext_wr));

   // R9
   ext_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_req |-> (ext_sel != 2'b00));
endmodule

// File: rtl/regpkt_bank.sv
module regpkt_bank
   import regpkt_pkg::*;
#(
   parameter int unsigned NBYTES  = MAP_BYTES,
   parameter logic [31:0] VERSION = 32'h0,
   parameter int unsigned ADDR_W  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [7:0]          wr_data,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [7:0]          rd_data,
   input  logic [TS_BYTES*8-1:0] ts_rx,
   input  logic [TS_BYTES*8-1:0] ts_tx,
   output logic [NBYTES*8-1:0] image
);
   if (NBYTES < MAP_BYTES || NBYTES > (1 << ADDR_W)) begin : g_bad_size
      $error("regpkt_bank: NBYTES out of range");
   end

   logic [7:0] byte_val [NBYTES];

   for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      if (byte_writable(i)) begin : g_rw
         logic [7:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else if (wr_en && wr_addr == ADDR_W'(i)) q <= wr_data;
         end
         assign byte_val[i]    = q;
         assign image[i*8 +: 8] = q;
      end else if (i >= VER_BASE && i < VER_BASE + 4) begin : g_ver
         assign byte_val[i]    = VERSION[(i - VER_BASE)*8 +: 8];
         assign image[i*8 +: 8] = '0;
      end else if (i >= TSRX_BASE && i < TSRX_BASE + TS_BYTES) begin : g_tsrx
         assign byte_val[i]    = ts_rx[(i - TSRX_BASE)*8 +: 8];
         assign image[i*8 +: 8] = '0;
      end else if (i >= TSTX_BASE && i < TSTX_BASE + TS_BYTES) begin : g_tstx
         assign byte_val[i]    = ts_tx[(i - TSTX_BASE)*8 +: 8];
         assign image[i*8 +: 8] = '0;
      end else begin : g_hole
         assign byte_val[i]    = '0;
         assign image[i*8 +: 8] = '0;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NBYTES; i++) begin
         if (rd_addr == ADDR_W'(i)) rd_data = byte_val[i];
      end
   end

   // R6 R7
   ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !byte_writable(32'(wr_addr)) |=> $stable(image));

   // R7
   hole_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(rd_addr) >= NBYTES) |-> (rd_data == 8'h00));
endmodule

// File: rtl/regpkt_engine.sv
module regpkt_engine
   import regpkt_pkg::*;
#(
   parameter logic [31:0] VERSION    = 32'hA5C3_0917,
   parameter int unsigned BANK_BYTES = MAP_BYTES
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rx_valid,
   input  logic [7:0]              rx_data,
   output logic                    rx_ready,
   output logic                    tx_valid,
   output logic [7:0]              tx_data,
   input  logic                    tx_ready,
   output logic                    ext_req,
   output logic [1:0]              ext_sel,
   output logic                    ext_wr,
   output logic [7:0]              ext_addr,
   output logic [7:0]              ext_wdata,
   input  logic [7:0]              ext_rdata,
   input  logic                    ext_ack,
   input  logic [63:0]             ts_rx,
   input  logic [63:0]             ts_tx,
   output logic [8*BANK_BYTES-1:0] cfg_image
);
   localparam int unsigned IW     = $clog2(PKT_BYTES);
   localparam int unsigned ADDR_W = 8;

   core_state_t           st_q;
   logic [7:0]            pkt_q [PKT_BYTES];
   logic [IW-1:0]         tx_idx_q;
   logic [2:0]            pair_q;
   logic [2:0]            last_q;
   logic [PKT_BYTES*8-1:0] frame;
   logic                  frame_done;
   logic                  cmd_rd, cmd_wr;
   logic [1:0]            cmd_tgt;
   logic [2:0]            cmd_cnt;
   logic [IW-1:0]         a_ptr, d_ptr;
   logic                  bank_we;
   logic [7:0]            bank_rdata;
   logic                  ext_start, ext_done;
   logic [7:0]            ext_rd_q;

   assign cmd_rd  = pkt_q[1][7];
   assign cmd_wr  = pkt_q[1][6];
   assign cmd_tgt = pkt_q[1][5:4];
   assign cmd_cnt = pkt_q[1][2:0];

   assign a_ptr = IW'({pair_q, 1'b0}) + IW'(2);
   assign d_ptr = a_ptr + IW'(1);

   assign bank_we   = (st_q == CS_BANK) && cmd_wr;
   assign ext_start = (st_q == CS_DECODE) && (cmd_tgt != TGT_BANK);

   regpkt_rx #(.NBYTES(PKT_BYTES), .MAGIC(PKT_MAGIC)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (rx_valid),
      .in_data    (rx_data),
      .hold       (st_q != CS_RECV),
      .in_ready   (rx_ready),
      .frame_done (frame_done),
      .frame      (frame)
   );

   regpkt_bank #(.NBYTES(BANK_BYTES), .VERSION(VERSION), .ADDR_W(ADDR_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bank_we),
      .wr_addr (pkt_q[a_ptr]),
      .wr_data (pkt_q[d_ptr]),
      .rd_addr (pkt_q[a_ptr]),
      .rd_data (bank_rdata),
      .ts_rx   (ts_rx),
      .ts_tx   (ts_tx),
      .image   (cfg_image)
   );

   regpkt_ext u_ext (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (ext_start),
      .start_wr    (cmd_wr),
      .start_sel   (cmd_tgt),
      .start_addr  (pkt_q[2]),
      .start_wdata (pkt_q[3]),
      .ext_ack     (ext_ack),
      .ext_rdata   (ext_rdata),
      .ext_req     (ext_req),
      .ext_sel     (ext_sel),
      .ext_wr      (ext_wr),
      .ext_addr    (ext_addr),
      .ext_wdata   (ext_wdata),
      .done        (ext_done),
      .rdata       (ext_rd_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= CS_RECV;
         pair_q   <= '0;
         last_q   <= '0;
         tx_idx_q <= '0;
      end else begin
         case (st_q)
            CS_RECV: if (frame_done) st_q <= CS_DECODE;
            CS_DECODE: begin
               pair_q <= '0;
               if (cmd_tgt == TGT_BANK) begin
                  last_q <= (cmd_rd && cmd_cnt != 3'd0) ? cmd_cnt - 3'd1 : 3'd0;
                  st_q   <= CS_BANK;
               end else begin
                  st_q <= CS_EXT;
               end
            end
            CS_BANK: begin
               if (pair_q == last_q) begin
                  st_q     <= CS_SEND;
                  tx_idx_q <= '0;
               end else begin
                  pair_q <= pair_q + 3'd1;
               end
            end
            CS_EXT: begin
               if (ext_done) begin
                  st_q     <= CS_SEND;
                  tx_idx_q <= '0;
               end
            end
            CS_SEND: begin
               if (tx_ready) begin
                  if (tx_idx_q == IW'(PKT_BYTES - 1)) st_q <= CS_RECV;
                  else tx_idx_q <= tx_idx_q + IW'(1);
               end
            end
            default: st_q <= CS_RECV;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (st_q == CS_RECV && frame_done) begin
         for (int k = 0; k < PKT_BYTES; k++) pkt_q[k] <= frame[k*8 +: 8];
      end else if (st_q == CS_BANK && cmd_rd) begin
         pkt_q[d_ptr] <= bank_rdata;
      end else if (st_q == CS_EXT && ext_done && cmd_rd) begin
         pkt_q[3] <= ext_rd_q;
      end
   end

   assign tx_valid = (st_q == CS_SEND);
   assign tx_data  = pkt_q[tx_idx_q];

   // R11
   rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !rx_ready);

   // R11
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

   // R9
   ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_req |-> !tx_valid && !rx_ready);
endmodule

// File: tb/regpkt_engine_test.sv
module regpkt_engine_test;
   localparam int          CLK_PER = 10;
   localparam logic [31:0] VER     = 32'hA5C3_0917;
   localparam logic [63:0] TSR     = 64'h0123_4567_89AB_CDEF;
   localparam logic [63:0] TST     = 64'hFEDC_BA98_7654_3210;
   localparam int          NB      = 48;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic rx_ready, tx_valid;
   logic [7:0] tx_data;
   logic tx_ready = 1'b0;
   logic ext_req, ext_wr;
   logic [1:0] ext_sel;
   logic [7:0] ext_addr, ext_wdata;
   logic [7:0] ext_rdata = '0;
   logic ext_ack = 1'b0;
   logic [8*NB-1:0] cfg_image;

   always #(CLK_PER/2) clk = ~clk;

   regpkt_engine #(.VERSION(VER), .BANK_BYTES(NB)) uut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
      .ext_req(ext_req), .ext_sel(ext_sel), .ext_wr(ext_wr), .ext_addr(ext_addr),
      .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_ack(ext_ack),
      .ts_rx(TSR), .ts_tx(TST), .cfg_image(cfg_image));

   int checks = 0;
   int fails = 0;
   int overlap = 0;
   int txv_cycles = 0;
   int ext_cnt = 0;
   logic [1:0] rec_sel;
   logic [7:0] rec_addr, rec_wdata;
   logic rec_wr;
   logic [7:0] model [NB];
   logic [7:0] sf [16];
   logic [7:0] rs [16];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   function automatic bit writable(int a);
      return (a < 12) || (a >= 34 && a < NB);
   endfunction

   function automatic logic [7:0] bank_exp(int a);
      if (writable(a)) return model[a];
      if (a >= 12 && a < 16) return 8'(VER >> ((a - 12) * 8));
      if (a >= 16 && a < 24) return 8'(TSR >> ((a - 16) * 8));
      if (a >= 24 && a < 32) return 8'(TST >> ((a - 24) * 8));
      return 8'h00;
   endfunction

   function automatic string addr_tag(int a, int i);
      if (i > 0) return "R5";
      if (a >= 12 && a < 16) return "R6";
      if (a >= 16 && a < 32) return "R8";
      if (!writable(a)) return "R7";
      return "R4";
   endfunction

   function automatic logic [7:0] ext_model(logic [1:0] sel, logic [7:0] a);
      return a ^ {sel, 6'h2B};
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         if (tx_valid && rx_ready) overlap++;
         if (tx_valid) txv_cycles++;
      end
   end

   initial begin
      int d;
      forever begin
         @(negedge clk);
         if (rst_n && ext_req) begin
            d = $urandom % 3;
            repeat (d) @(negedge clk);
            ext_ack   = 1'b1;
            ext_rdata = ext_model(ext_sel, ext_addr);
            rec_sel   = ext_sel;
            rec_addr  = ext_addr;
            rec_wr    = ext_wr;
            rec_wdata = ext_wdata;
            ext_cnt++;
            @(negedge clk);
            ext_ack = 1'b0;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_up();
   end

   task automatic send_raw(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = b;
      while (!rx_ready) @(negedge clk);
      @(posedge clk);
   endtask

   task automatic rx_idle();
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic send_frame();
      for (int k = 0; k < 16; k++) send_raw(sf[k]);
      rx_idle();
   endtask

   task automatic collect();
      for (int k = 0; k < 16; k++) begin
         forever begin
            @(negedge clk);
            tx_ready = ($urandom % 4) != 0;
            if (tx_valid && tx_ready) break;
         end
         rs[k] = tx_data;
         @(posedge clk);
      end
      @(negedge clk);
      tx_ready = 1'b0;
   endtask

   task automatic chk_image(input string req);
      bit ok = 1'b1;
      for (int a = 0; a < NB; a++) begin
         if (cfg_image[a*8 +: 8] !== (writable(a) ? model[a] : 8'h00)) ok = 1'b0;
      end
      chk(ok, req, "cfg_image vs model", 32'(cfg_image[31:0]),
          {model[3], model[2], model[1], model[0]});
   endtask

   task automatic run_pkt(input logic [7:0] cmd);
      int prev;
      int n;
      int a;
      logic [1:0] tgt;
      sf[0] = 8'h4E;
      sf[1] = cmd;
      prev = ext_cnt;
      send_frame();
      collect();
      tgt = cmd[5:4];
      chk(rs[0] == 8'h4E, "R1", "answer sync byte", 32'(rs[0]), 32'h4E);
      chk(rs[1] == cmd, "R1", "answer command echo", 32'(rs[1]), 32'(cmd));
      if (tgt == 2'b00) begin
         if (cmd[7]) begin
            n = (cmd[2:0] == 3'd0) ? 1 : int'(cmd[2:0]);
            for (int i = 0; i < n; i++) begin
               a = int'(sf[2 + 2*i]);
               chk(rs[3 + 2*i] == bank_exp(a), addr_tag(a, i), "bank read",
                   32'(rs[3 + 2*i]), 32'(bank_exp(a)));
            end
         end else begin
            a = int'(sf[2]);
            if (writable(a)) model[a] = sf[3];
            chk_image(writable(a) ? "R4" : ((a >= 12 && a < 16) ? "R6" : "R7"));
         end
      end else begin
         chk(ext_cnt == prev + 1, "R9", "device transfer count", 32'(ext_cnt), 32'(prev + 1));
         chk(rec_sel == tgt && rec_addr == sf[2] && rec_wr == cmd[6] &&
             (!cmd[6] || rec_wdata == sf[3]), "R9", "device transfer fields",
             {21'd0, rec_wr, rec_sel, rec_addr}, {21'd0, cmd[6], tgt, sf[2]});
         if (cmd[7])
            chk(rs[3] == ext_model(tgt, sf[2]), "R9", "device read data",
                32'(rs[3]), 32'(ext_model(tgt, sf[2])));
      end
   endtask

   task automatic fill(input logic [7:0] a0, input logic [7:0] d0);
      for (int k = 2; k < 16; k++) sf[k] = 8'h00;
      sf[2] = a0;
      sf[3] = d0;
   endtask

   initial begin
      int base;
      void'($urandom(32'd4711));
      for (int a = 0; a < NB; a++) model[a] = 8'h00;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12
      chk(rx_ready && !tx_valid && !ext_req && (cfg_image == '0), "R12", "reset state",
          {28'd0, rx_ready, tx_valid, ext_req, 1'b0}, 32'h8);

      // R4: control word written a byte at a time, read back in one request
      for (int i = 0; i < 4; i++) begin
         fill(8'(i), 8'h10 + 8'(i));
         run_pkt(8'h41);
      end
      fill(8'd0, 8'h00);
      sf[4] = 8'd1; sf[6] = 8'd2; sf[8] = 8'd3;
      run_pkt(8'h84);
      chk({rs[9], rs[7], rs[5], rs[3]} == 32'h1312_1110, "R4", "little-endian word",
          {rs[9], rs[7], rs[5], rs[3]}, 32'h1312_1110);

      // R6: write to the version byte has no effect
      fill(8'd13, 8'hFF);
      run_pkt(8'h41);
      fill(8'd13, 8'h00);
      run_pkt(8'h81);

      // R5: count of zero acts as one
      fill(8'd2, 8'h77);
      run_pkt(8'h80);

      // R7: holes and addresses past the map
      fill(8'd33, 8'hAA);
      run_pkt(8'h41);
      fill(8'd32, 8'h00);
      sf[4] = 8'd33; sf[6] = 8'd60;
      run_pkt(8'h83);

      // R8: timestamps and version across seven pairs
      fill(8'd16, 8'h00);
      sf[4] = 8'd17; sf[6] = 8'd23; sf[8] = 8'd24; sf[10] = 8'd31; sf[12] = 8'd12; sf[14] = 8'd15;
      run_pkt(8'h87);

      // R9: device write with a count above one makes one transfer
      fill(8'h21, 8'h9C);
      sf[4] = 8'h22; sf[5] = 8'h33;
      run_pkt(8'h55);
      fill(8'h44, 8'h00);
      run_pkt(8'hB0);
      fill(8'h05, 8'h00);
      run_pkt(8'hA1);

      // R3: bad direction bits abandon the request, no answer
      base = txv_cycles;
      send_raw(8'h11);
      send_raw(8'h4E);
      send_raw(8'hC3);
      send_raw(8'h4E);
      send_raw(8'h05);
      for (int k = 0; k < 14; k++) send_raw(8'h00);
      rx_idle();
      repeat (30) @(negedge clk);
      chk(txv_cycles == base, "R3", "no answer to bad command", 32'(txv_cycles), 32'(base));

      // R2: garbage ahead of a request is discarded
      send_raw(8'h33);
      send_raw(8'h77);
      fill(8'd1, 8'h00);
      run_pkt(8'h81);
      chk(rs[3] == 8'h11, "R2", "request after resync", 32'(rs[3]), 32'h11);

      // R11: next request pushed while the answer is drained
      fill(8'd0, 8'h00);
      sf[4] = 8'd3;
      sf[0] = 8'h4E; sf[1] = 8'h82;
      send_frame();
      fill(8'd12, 8'h00);
      sf[4] = 8'd15;
      sf[0] = 8'h4E; sf[1] = 8'h82;
      fork
         send_frame();
         collect();
      join
      chk(rs[3] == 8'h10 && rs[5] == 8'h13, "R11", "first answer under overlap",
          {16'd0, rs[3], rs[5]}, 32'h1013);
      collect();
      chk(rs[1] == 8'h82 && rs[3] == VER[7:0] && rs[5] == VER[31:24], "R11",
          "second answer under overlap", {8'd0, rs[1], rs[3], rs[5]},
          {8'd0, 8'h82, VER[7:0], VER[31:24]});

      // Random mix
      for (int it = 0; it < 80; it++) begin
         logic rd;
         logic [1:0] tgt;
         logic [2:0] cnt;
         rd  = 1'($urandom % 2);
         tgt = 2'($urandom % 4);
         cnt = 3'($urandom % 8);
         for (int k = 2; k < 16; k++) sf[k] = 8'($urandom);
         if (tgt == 2'b00)
            for (int k = 2; k < 16; k += 2) sf[k] = 8'($urandom % 64);
         run_pkt({rd, !rd, tgt, 1'b0, cnt});
      end

      chk(overlap == 0, "R11", "rx_ready while answering", 32'(overlap), 32'd0);
      finish_up();
   end
endmodule